// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two signed two's-complement operands, a multiplicand X of `XW` bits and a multiplier Y of `YW` bits. It returns the full signed product of `XW+YW` bits. The multiplier is recoded in overlapping three-bit windows that advance by two positions. Each window chooses one of five actions on the multiplicand: zero, plus one times, plus two times, minus one times or minus two times. This needs half as many partial-product rows as a plain AND-array.

Negation is done by inverting the selected row and adding a one at that row's lowest weight. That one travels as a separate carry vector, so no extra adder row is needed. The rows are sign-extended to the product width, shifted by twice their group index and summed without registers between them.

A result register captures the sum when `start` is high. The result appears one cycle later with `valid`. Between operations the register holds its value. An odd `YW` is handled by repeating the sign bit of Y once before recoding.

Top module: `booth_mult`

## Requirements
- R1: While `rst_n` is low, `valid` is 0 and `product` is all zeros.
- R2: `valid` is 1 in exactly the cycle after a cycle in which `start` was sampled high, and 0 after any cycle in which `start` was low.
- R3: When `valid` is 1, `product` equals the signed product of the `x_in` and `y_in` values sampled together with `start`, as a two's-complement value of `XW+YW` bits.
- R4: After a cycle in which `start` is low, `product` keeps its previous value.
- R5: Each three-bit window (y[2k+1], y[2k], y[2k-1]) selects by this table: 000 and 111 give zero; 001 and 010 give +X; 011 gives +2X; 100 gives -2X; 101 and 110 give -X. The row for window k carries weight 4^k. All multiplier values, combined with several multiplicands, give correct products.
- R6: The lowest window uses a zero below bit 0. Y = -1 gives -X, and Y = 1 gives X.
- R7: The most negative operands, X = -2^(XW-1) and Y = -2^(YW-1), give +2^(XW+YW-2). Whenever X and Y are both non-zero, the product's top bit is the XOR of the operands' top bits.
- R8: X = 25 and Y = -18 give -450. Here the windows produce -2X at weight 1, zero at weight 4 and -X at weight 16.
- R9: With odd `YW`, Y is sign-extended by one bit before recoding, and products stay correct.
- R10: Starts on consecutive cycles each produce their own result, in order, one cycle after their start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture operands this cycle |
| x_in | input | XW | Signed multiplicand |
| y_in | input | YW | Signed multiplier |
| valid | output | 1 | Product register holds a fresh result |
| product | output | XW+YW | Signed product |

## Verification
Two things can happen in one clock edge: a new operand pair is captured, and the previous pair's result is presented on `valid` and `product`. Back-to-back starts provoke this, so each result must be the one matching the start one cycle earlier and not its neighbour. A second coincidence lies inside the datapath: in one operand, a negated doubled row and its carry-in one land at the same weight as a positive row from a neighbouring window. The most negative operand pair and a full sweep of Y provoke this. Both cases are judged against products the bench computes with integer arithmetic.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [2:0] {
    SEL_ZERO = 3'd0,
    SEL_POS1 = 3'd1,
    SEL_POS2 = 3'd2,
    SEL_NEG1 = 3'd3,
    SEL_NEG2 = 3'd4
  } sel_e;
endpackage

// File: rtl/booth_enc.sv
module booth_enc
  import booth_pkg::*;
(
  input  logic [2:0] win,
  output sel_e       sel
);
  // win = {y[2k+1], y[2k], y[2k-1]}
  always_comb begin
    unique case (win)
      3'b001, 3'b010: sel = SEL_POS1;
      3'b011:         sel = SEL_POS2;
      3'b100:         sel = SEL_NEG2;
      3'b101, 3'b110: sel = SEL_NEG1;
      default:        sel = SEL_ZERO;
    endcase
  end
endmodule

// File: rtl/booth_pp.sv
module booth_pp
  import booth_pkg::*;
#(
  parameter int XW = 8,
  parameter int PW = 16,
  parameter int SH = 0
) (
  input  logic [XW-1:0] x,
  input  sel_e          sel,
  output logic [PW-1:0] row,
  output logic [PW-1:0] inc
);
  logic [PW-1:0] x_ext;
  logic [PW-1:0] mag;
  logic [PW-1:0] flip;
  logic          neg;

  assign x_ext = {{(PW-XW){x[XW-1]}}, x};

  always_comb begin
    unique case (sel)
      SEL_POS1, SEL_NEG1: mag = x_ext;
      SEL_POS2, SEL_NEG2: mag = x_ext << 1;
      default:            mag = '0;
    endcase
    neg  = (sel == SEL_NEG1) || (sel == SEL_NEG2);
    flip = neg ? ~mag : mag;
  end

  // inverted row plus a one at the row's lowest weight forms the negation
  assign row = flip << SH;
  assign inc = {{(PW-1){1'b0}}, neg} << SH;
endmodule

// File: rtl/booth_acc.sv
module booth_acc #(
  parameter int PW = 16,
  parameter int G  = 4
) (
  input  logic [G-1:0][PW-1:0] rows,
  input  logic [G-1:0][PW-1:0] incs,
  output logic [PW-1:0]        sum
);
  logic [PW-1:0] cin_vec;

  always_comb begin
    cin_vec = '0;
    for (int k = 0; k < G; k++) cin_vec = cin_vec | incs[k];
  end

  always_comb begin
    sum = cin_vec;
    for (int k = 0; k < G; k++) sum = sum + rows[k];
  end
endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int XW = 8,
  parameter int YW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [XW-1:0]    x_in,
  input  logic [YW-1:0]    y_in,
  output logic             valid,
  output logic [XW+YW-1:0] product
);
  localparam int YE = YW + (YW % 2);
  localparam int G  = YE / 2;
  localparam int PW = XW + YW;

  // yx[0] is the implicit zero below bit 0
  logic [YE:0] yx;

  generate
    if (YE != YW) begin : g_odd
      assign yx = {y_in[YW-1], y_in, 1'b0};
    end else begin : g_even
      assign yx = {y_in, 1'b0};
    end
  endgenerate

  logic [G-1:0][PW-1:0] rows;
  logic [G-1:0][PW-1:0] incs;
  logic [PW-1:0]        sum;

  generate
    for (genvar k = 0; k < G; k++) begin : g_grp
      sel_e sel;
      booth_enc i_enc (
        .win (yx[2*k+2:2*k]),
        .sel (sel)
      );
      booth_pp #(.XW(XW), .PW(PW), .SH(2*k)) i_pp (
        .x   (x_in),
        .sel (sel),
        .row (rows[k]),
        .inc (incs[k])
      );
    end
  endgenerate

  booth_acc #(.PW(PW), .G(G)) i_acc (
    .rows (rows),
    .incs (incs),
    .sum  (sum)
  );

  logic [PW-1:0] prod_q, prod_d;
  logic          vld_q, vld_d;

  always_comb begin
    vld_d  = start;
    prod_d = start ? sum : prod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      prod_q <= '0;
    end else begin
      vld_q  <= vld_d;
      prod_q <= prod_d;
    end
  end

  assign valid   = vld_q;
  assign product = prod_q;
endmodule

module booth_mult_chk #(
  parameter int XW = 8,
  parameter int YW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [XW-1:0]    x_in,
  input logic [YW-1:0]    y_in,
  input logic             valid,
  input logic [XW+YW-1:0] product
);
  localparam int PW = XW + YW;
  logic signed [PW-1:0] ref_w;
  assign ref_w = $signed(x_in) * $signed(y_in);

  // R2
  valid_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid);
  // R3
  product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (product == $past(ref_w)));
  // R4
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(product));
  // R7
  product_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (x_in != '0) && (y_in != '0)) |=>
      (product[PW-1] == ($past(x_in[XW-1]) ^ $past(y_in[YW-1]))));
endmodule

bind booth_mult booth_mult_chk #(.XW(XW), .YW(YW)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .x_in    (x_in),
  .y_in    (y_in),
  .valid   (valid),
  .product (product)
);

// File: tb/test_booth_mult.sv
module test_booth_mult;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] xa = '0;
  logic [7:0] ya = '0;

  logic        v8, v5;
  logic [15:0] p8;
  logic [10:0] p5;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    int    exp;
    string req;
  } item_t;

  item_t q8[$];
  item_t q5[$];

  always #(CLK_P/2) clk = ~clk;

  booth_mult #(.XW(8), .YW(8)) i_booth_mult (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_in(xa), .y_in(ya), .valid(v8), .product(p8)
  );

  // R9: odd multiplier width, driven from the low bits of the same operands
  booth_mult #(.XW(6), .YW(5)) i_booth_mult_odd (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_in(xa[5:0]), .y_in(ya[4:0]), .valid(v5), .product(p5)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [7:0] a, input logic [7:0] b, input string req);
    logic signed [7:0] sa;
    logic signed [7:0] sb;
    logic signed [5:0] oa;
    logic signed [4:0] ob;
    item_t it;
    @(negedge clk);
    sa = a; sb = b; oa = a[5:0]; ob = b[4:0];
    xa = a; ya = b; start = 1'b1;
    it.exp = int'(sa) * int'(sb); it.req = req; q8.push_back(it);
    it.exp = int'(oa) * int'(ob); it.req = {req, "/R9"}; q5.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // monitor: scoreboard pops expected items when results appear
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (v8) begin
        if (q8.size() == 0) check(1'b0, "R2 unexpected valid (even)", 1, 0);
        else begin
          item_t it;
          logic signed [15:0] ps;
          it = q8.pop_front();
          ps = p8;
          check(int'(ps) == it.exp, {it.req, " R3"}, int'(ps), it.exp);
        end
      end
      if (v5) begin
        if (q5.size() == 0) check(1'b0, "R2 unexpected valid (odd)", 1, 0);
        else begin
          item_t it;
          logic signed [10:0] ps;
          it = q5.pop_front();
          ps = p5;
          check(int'(ps) == it.exp, {it.req, " R3"}, int'(ps), it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] held;
    #(CLK_P * 2 + 2);
    // R1 reset state
    check(v8 == 1'b0 && p8 == '0, "R1 reset even", int'(p8), 0);
    check(v5 == 1'b0 && p5 == '0, "R1 reset odd", int'(p5), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    check(v8 == 1'b0, "R2 idle after reset", int'(v8), 0);

    // R8 worked example
    do_op(8'd25, 8'hEE, "R8");
    idle(1);
    // R6 lowest window
    do_op(8'd37, 8'hFF, "R6 y=-1");
    do_op(8'd37, 8'h01, "R6 y=1");
    do_op(8'h80, 8'hFF, "R6 minX*-1");
    // R7 extremes
    do_op(8'h80, 8'h80, "R7 min*min");
    do_op(8'h7F, 8'h80, "R7 max*min");
    do_op(8'h7F, 8'h7F, "R7 max*max");
    idle(1);

    // R4 hold: product unchanged over idle cycles
    held = p8;
    idle(3);
    check(p8 == held && v8 == 1'b0, "R4 hold", int'(p8), int'(held));

    // R5, R10: full multiplier sweep, back-to-back starts
    foreach (xa_set[i]) begin
      for (int y = -128; y < 128; y++) do_op(xa_set[i], 8'(y), "R5 R10 sweep");
      idle(2);
    end

    // R10 alternating gaps
    for (int k = 0; k < 8; k++) begin
      do_op(8'(k * 29 - 100), 8'(77 - k * 19), "R10 gapped");
      if (k % 2 == 1) idle(1);
    end
    idle(3);
    check(q8.size() == 0, "R2 missing even results", q8.size(), 0);
    check(q5.size() == 0, "R2 missing odd results", q5.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  logic [7:0] xa_set [7] = '{8'd0, 8'd1, 8'hFF, 8'd25, 8'h80, 8'h7F, 8'hB3};
endmodule